// File: doc/BRIEF.md
# Descriptor Chain Channel Sequencer

This block is the state machine of one copy channel. It walks a linked list of copy descriptors held in memory. For each descriptor it fetches the five descriptor words and reads the source words into a local buffer. It then writes those words to the destination, and it may post a completion word. After that it decides whether to follow the next pointer. The register block drives the channel with one-cycle start, append and reset pulses. The register block also supplies the chain and completion addresses.

Every memory access goes through a single request and response port. Only one access is outstanding at a time. Addresses are byte addresses and every access moves one 32-bit word. A descriptor at address D has this layout, with the word order fixed by the fetch sequence:
- D+0: next pointer.
- D+4: control. Bit 0 marks a null descriptor. Bit 1 asks for a completion write.
- D+8: length in words.
- D+12: source address.
- D+16: destination address.

The status word has four fields:
- Bits [ADDR_W-1:6]: the address of the last completed descriptor with its low six bits dropped.
- Bits [5:3]: always zero.
- Bits [2:1]: the transfer-status field.
- Bit 0: always zero on the port.

Top module: `desc_chain_seq`

## Requirements
- R1: After reset the channel is idle: `busy` is 0, `chanState` is 0 (idle), no request is issued, and `statusWord` is 0x6. The value 0x6 means the transfer-status field [2:1] is 3 and every other bit is zero.
- R2: A start pulse while idle clears the transfer-status field. The channel then reads five words starting at `chainAddr`, in the order next, control, length, source, destination. `chanState` encodes states as idle 0, next-pointer fetch 1, descriptor fetch 2, copy read 3, copy write 4 and completion write 5.
- R3: A non-null descriptor reads its words from the source address and then writes them in the same order to the destination address, stepping by 4. The number of words is the length field, but never more than BUF_WORDS; a longer length is cut to BUF_WORDS.
- R4: After the last copy write, status bits [ADDR_W-1:6] take bits [ADDR_W-1:6] of the descriptor's address. If and only if control bit 1 is set, the status word with bit 0 set is then written to `complAddr`.
- R5: A descriptor with control bit 0 set performs no copy and no completion write, and leaves the status word unchanged. The channel then follows a nonzero next pointer or, when the pointer is zero, goes idle.
- R6: When a descriptor finishes, the channel acts on the first true condition in this order:
  - a deferred reset is pending;
  - the next pointer is nonzero;
  - an append is pending;
  - none of these: go idle.
- R7: An append pulse while idle issues exactly one read: of the next-pointer word of the last fetched descriptor. A zero result returns the channel to idle with no further access. A nonzero result starts a descriptor fetch at that address.
- R8: An append pulse while busy is remembered. If the finishing descriptor has a zero next pointer, the channel re-reads that descriptor's next pointer and continues from it.
- R9: A reset pulse while idle sets the transfer-status field to 3. While busy, the reset waits for the current descriptor, including its completion write, to finish. The channel then goes idle with the status field at 3. It follows no next pointer and drops any pending append.
- R10: A start pulse while busy is ignored: the running chain continues and the new chain address is not fetched.
- R11: A request holds its address, direction and data until it is accepted. After acceptance no new request is issued until the response arrives.
- R12: A non-null descriptor with length 0 does no source read and no destination write. It still updates the status word and, if flagged, writes the completion word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Start pulse, one cycle |
| cmdAppend | input | 1 | Append pulse, one cycle |
| cmdReset | input | 1 | Channel reset pulse, one cycle |
| chainAddr | input | ADDR_W | First descriptor address, used on start |
| complAddr | input | ADDR_W | Target of the completion word |
| memReqValid | output | 1 | Memory request present |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | 1 for write, 0 for read |
| memReqAddr | output | ADDR_W | Byte address of the word |
| memReqWdata | output | ADDR_W | Write data |
| memRspValid | input | 1 | Response pulse for the outstanding request |
| memRspData | input | ADDR_W | Read data carried with the response |
| busy | output | 1 | Channel not idle |
| chanState | output | 3 | Current state code |
| statusWord | output | ADDR_W | Completed-descriptor field and transfer status |

## Verification
The memory model answers with varying latency and drops ready on a fixed pattern. This keeps the request-hold and single-outstanding rules under pressure throughout. The copy path runs with several descriptor shapes:
- A short flagged copy, which shows the completion word and the status update.
- A two-descriptor chain whose second length exceeds the buffer. It separates the clamping from a plain next-pointer walk and shows that the address shift drops the low bits.
- A null descriptor at the head of a chain and a lone null descriptor. These show that a skip neither copies nor reports.
- A zero-length descriptor, which separates the status update from the data movement.

Append and reset are each sent once while idle and once mid-copy. A start is sent mid-copy at another chain. Destination words that must stay untouched show whether a command took effect too early, too late or not at all.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_ADDR_FETCH = 3'd1,
    ST_DESC_FETCH = 3'd2,
    ST_READ       = 3'd3,
    ST_WRITE      = 3'd4,
    ST_CMPL       = 3'd5
  } chanState_e;

  typedef enum logic [2:0] {
    RQ_NEXT,
    RQ_DESC,
    RQ_SRC,
    RQ_DST,
    RQ_CMPL
  } reqKind_e;

  typedef enum logic [1:0] {
    DS_KEEP,
    DS_CHAIN,
    DS_NEXT,
    DS_RSP
  } descSel_e;

  // strobes from control to datapath
  typedef struct packed {
    reqKind_e reqKind;
    descSel_e descSel;
    logic     clrIdx;
    logic     incIdx;
    logic     capDesc;
    logic     capBuf;
    logic     setDone;
    logic     xferClr;
    logic     xferSet3;
  } dpCtl_t;

  localparam int DESC_WORDS = 5;
  localparam int NULL_BIT   = 0;
  localparam int CPSTS_BIT  = 1;
  localparam logic [1:0] XFER_RESET = 2'd3;

endpackage

// File: rtl/dcs_ctrl.sv
module dcs_ctrl
  import dcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       cmdAppend,
  input  logic       cmdReset,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       lastDescWord,
  input  logic       lastCopy,
  input  logic       lenZero,
  input  logic       descNull,
  input  logic       descCpSts,
  input  logic       nextZero,
  input  logic       rspZero,
  output logic       memReqValid,
  output logic       memReqWrite,
  output dpCtl_t     ctl,
  output logic [2:0] chanState,
  output logic       busy
);

  chanState_e state, nextState;
  logic waitRsp, waitNxt;
  logic appPend, rstPend;
  logic doFinish, consumeApp, enterIdle;

  assign busy      = (state != ST_IDLE);
  assign chanState = state;
  assign enterIdle = (state != ST_IDLE) && (nextState == ST_IDLE);

  always_comb begin
    ctl.reqKind  = RQ_NEXT;
    ctl.descSel  = DS_KEEP;
    ctl.clrIdx   = 1'b0;
    ctl.incIdx   = 1'b0;
    ctl.capDesc  = 1'b0;
    ctl.capBuf   = 1'b0;
    ctl.setDone  = 1'b0;
    ctl.xferClr  = 1'b0;
    ctl.xferSet3 = 1'b0;
    nextState    = state;
    memReqValid  = 1'b0;
    memReqWrite  = 1'b0;
    waitNxt      = waitRsp;
    doFinish     = 1'b0;
    consumeApp   = 1'b0;

    if (state != ST_IDLE) begin
      memReqValid = !waitRsp;
      if (!waitRsp && memReqReady) waitNxt = 1'b1;
      if (waitRsp && memRspValid)  waitNxt = 1'b0;
    end

    unique case (state)
      ST_IDLE: begin
        if (cmdStart) begin
          ctl.xferClr = 1'b1;
          ctl.descSel = DS_CHAIN;
          ctl.clrIdx  = 1'b1;
          nextState   = ST_DESC_FETCH;
        end else if (cmdAppend) begin
          nextState = ST_ADDR_FETCH;
        end else if (cmdReset) begin
          ctl.xferSet3 = 1'b1;
        end
      end
      ST_ADDR_FETCH: begin
        ctl.reqKind = RQ_NEXT;
        if (waitRsp && memRspValid) begin
          if (rspZero) begin
            nextState = ST_IDLE;
          end else begin
            ctl.descSel = DS_RSP;
            ctl.clrIdx  = 1'b1;
            nextState   = ST_DESC_FETCH;
          end
        end
      end
      ST_DESC_FETCH: begin
        ctl.reqKind = RQ_DESC;
        if (waitRsp && memRspValid) begin
          ctl.capDesc = 1'b1;
          ctl.incIdx  = 1'b1;
          if (lastDescWord) begin
            if (descNull) begin
              doFinish = 1'b1;
            end else if (lenZero) begin
              ctl.setDone = 1'b1;
              if (descCpSts) nextState = ST_CMPL;
              else           doFinish  = 1'b1;
            end else begin
              ctl.clrIdx = 1'b1;
              nextState  = ST_READ;
            end
          end
        end
      end
      ST_READ: begin
        ctl.reqKind = RQ_SRC;
        if (waitRsp && memRspValid) begin
          ctl.capBuf = 1'b1;
          ctl.incIdx = 1'b1;
          if (lastCopy) begin
            ctl.clrIdx = 1'b1;
            nextState  = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        ctl.reqKind = RQ_DST;
        memReqWrite = 1'b1;
        if (waitRsp && memRspValid) begin
          ctl.incIdx = 1'b1;
          if (lastCopy) begin
            ctl.setDone = 1'b1;
            if (descCpSts) nextState = ST_CMPL;
            else           doFinish  = 1'b1;
          end
        end
      end
      ST_CMPL: begin
        ctl.reqKind = RQ_CMPL;
        memReqWrite = 1'b1;
        if (waitRsp && memRspValid) doFinish = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase

    // end-of-descriptor decision, fixed priority
    if (doFinish) begin
      if (rstPend) begin
        nextState = ST_IDLE;
      end else if (!nextZero) begin
        ctl.descSel = DS_NEXT;
        ctl.clrIdx  = 1'b1;
        nextState   = ST_DESC_FETCH;
      end else if (appPend) begin
        consumeApp = 1'b1;
        nextState  = ST_ADDR_FETCH;
      end else begin
        nextState = ST_IDLE;
      end
    end

    if (enterIdle && rstPend) ctl.xferSet3 = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitRsp <= 1'b0;
      appPend <= 1'b0;
      rstPend <= 1'b0;
    end else begin
      state   <= nextState;
      waitRsp <= waitNxt;
      if (enterIdle) begin
        appPend <= 1'b0;
        rstPend <= 1'b0;
      end else begin
        if (busy && cmdAppend)  appPend <= 1'b1;
        else if (consumeApp)    appPend <= 1'b0;
        if (busy && cmdReset)   rstPend <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dcs_datapath.sv
module dcs_datapath
  import dcs_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUF_WORDS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] chainAddr,
  input  logic [ADDR_W-1:0] complAddr,
  input  logic [ADDR_W-1:0] rspData,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [ADDR_W-1:0] reqWdata,
  output logic [ADDR_W-1:0] statusWord,
  output logic              lastDescWord,
  output logic              lastCopy,
  output logic              lenZero,
  output logic              descNull,
  output logic              descCpSts,
  output logic              nextZero,
  output logic              rspZero
);

  localparam int MAXW      = (BUF_WORDS > DESC_WORDS) ? BUF_WORDS : DESC_WORDS;
  localparam int IDX_W     = $clog2(MAXW + 1);
  localparam int BUF_IDX_W = $clog2(BUF_WORDS);
  localparam int FIELD_W   = ADDR_W - 6;

  logic [ADDR_W-1:0]  lastDesc, dNext, dLen, dSrc, dDst;
  logic [1:0]         dFlags;
  logic [IDX_W-1:0]   idx, effLen;
  logic [FIELD_W-1:0] complField;
  logic [1:0]         xfer;
  logic [ADDR_W-1:0]  copyBuf [BUF_WORDS];
  logic [ADDR_W-1:0]  wordOff, bufWord;

  assign effLen  = (dLen > ADDR_W'(BUF_WORDS)) ? IDX_W'(BUF_WORDS) : dLen[IDX_W-1:0];
  assign wordOff = {{(ADDR_W-IDX_W-2){1'b0}}, idx, 2'b00};

  assign lastDescWord = (idx == IDX_W'(DESC_WORDS - 1));
  assign lastCopy     = ((idx + IDX_W'(1)) == effLen);
  assign lenZero      = (dLen == '0);
  assign descNull     = dFlags[NULL_BIT];
  assign descCpSts    = dFlags[CPSTS_BIT];
  assign nextZero     = (dNext == '0);
  assign rspZero      = (rspData == '0);

  assign statusWord = {complField, 3'b000, xfer, 1'b0};

  // index walks descriptor words or copy words
  always_ff @(posedge clk) begin
    if (!rstN)           idx <= '0;
    else if (ctl.clrIdx) idx <= '0;
    else if (ctl.incIdx) idx <= idx + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastDesc <= '0;
      dNext    <= '0;
      dFlags   <= '0;
      dLen     <= '0;
      dSrc     <= '0;
      dDst     <= '0;
    end else begin
      unique case (ctl.descSel)
        DS_CHAIN: lastDesc <= chainAddr;
        DS_NEXT:  lastDesc <= dNext;
        DS_RSP:   lastDesc <= rspData;
        default:  ;
      endcase
      if (ctl.capDesc) begin
        case (idx)
          IDX_W'(0): dNext  <= rspData;
          IDX_W'(1): dFlags <= {rspData[CPSTS_BIT], rspData[NULL_BIT]};
          IDX_W'(2): dLen   <= rspData;
          IDX_W'(3): dSrc   <= rspData;
          IDX_W'(4): dDst   <= rspData;
          default:   ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      complField <= '0;
      xfer       <= XFER_RESET;
    end else begin
      if (ctl.setDone)       complField <= lastDesc[ADDR_W-1:6];
      if (ctl.xferSet3)      xfer <= XFER_RESET;
      else if (ctl.xferClr)  xfer <= 2'd0;
    end
  end

  for (genvar g = 0; g < BUF_WORDS; g++) begin : g_buf
    always_ff @(posedge clk) begin
      if (ctl.capBuf && idx == IDX_W'(g)) copyBuf[g] <= rspData;
    end
  end

  assign bufWord = (idx < IDX_W'(BUF_WORDS)) ? copyBuf[idx[BUF_IDX_W-1:0]] : '0;

  always_comb begin
    unique case (ctl.reqKind)
      RQ_NEXT: reqAddr = lastDesc;
      RQ_DESC: reqAddr = lastDesc + wordOff;
      RQ_SRC:  reqAddr = dSrc + wordOff;
      RQ_DST:  reqAddr = dDst + wordOff;
      RQ_CMPL: reqAddr = complAddr;
      default: reqAddr = lastDesc;
    endcase
    reqWdata = (ctl.reqKind == RQ_CMPL) ? (statusWord | ADDR_W'(1)) : bufWord;
  end

endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq
  import dcs_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUF_WORDS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdAppend,
  input  logic              cmdReset,
  input  logic [ADDR_W-1:0] chainAddr,
  input  logic [ADDR_W-1:0] complAddr,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] memReqWdata,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              busy,
  output logic [2:0]        chanState,
  output logic [ADDR_W-1:0] statusWord
);

  dpCtl_t ctl;
  logic lastDescWord, lastCopy, lenZero, descNull, descCpSts, nextZero, rspZero;

  dcs_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdStart     (cmdStart),
    .cmdAppend    (cmdAppend),
    .cmdReset     (cmdReset),
    .memReqReady  (memReqReady),
    .memRspValid  (memRspValid),
    .lastDescWord (lastDescWord),
    .lastCopy     (lastCopy),
    .lenZero      (lenZero),
    .descNull     (descNull),
    .descCpSts    (descCpSts),
    .nextZero     (nextZero),
    .rspZero      (rspZero),
    .memReqValid  (memReqValid),
    .memReqWrite  (memReqWrite),
    .ctl          (ctl),
    .chanState    (chanState),
    .busy         (busy)
  );

  dcs_datapath #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .chainAddr    (chainAddr),
    .complAddr    (complAddr),
    .rspData      (memRspData),
    .reqAddr      (memReqAddr),
    .reqWdata     (memReqWdata),
    .statusWord   (statusWord),
    .lastDescWord (lastDescWord),
    .lastCopy     (lastCopy),
    .lenZero      (lenZero),
    .descNull     (descNull),
    .descCpSts    (descCpSts),
    .nextZero     (nextZero),
    .rspZero      (rspZero)
  );

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker
  import dcs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdStart,
  input logic              cmdReset,
  input logic [ADDR_W-1:0] complAddr,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic [ADDR_W-1:0] memReqWdata,
  input logic [2:0]        chanState,
  input logic [ADDR_W-1:0] statusWord
);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) && $stable(memReqWrite));

  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady |=> !memReqValid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    chanState == ST_IDLE |-> !memReqValid);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    chanState == ST_IDLE && cmdStart |=> chanState == ST_DESC_FETCH && statusWord[2:1] == 2'd0);

  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    chanState == ST_IDLE && cmdReset && !cmdStart |=> statusWord[2:1] == 2'd3);

  assert_cmpl_word_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && chanState == ST_CMPL |-> memReqWrite && memReqAddr == complAddr &&
      memReqWdata[0] && memReqWdata[ADDR_W-1:6] == statusWord[ADDR_W-1:6]);

  assert_write_states_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqWrite |-> chanState == ST_WRITE || chanState == ST_CMPL);

endmodule

bind desc_chain_seq dcs_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_desc_chain_seq.sv
module test_desc_chain_seq;

  localparam int AW   = 32;
  localparam int BUFW = 8;
  localparam logic [31:0] CMPL_AT = 32'h7F0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 1'b0, cmdAppend = 1'b0, cmdReset = 1'b0;
  logic [AW-1:0] chainAddr = '0;
  logic [AW-1:0] complAddr = CMPL_AT;
  logic memReqValid, memReqReady, memReqWrite;
  logic [AW-1:0] memReqAddr, memReqWdata;
  logic memRspValid = 1'b0;
  logic [AW-1:0] memRspData = '0;
  logic busy;
  logic [2:0] chanState;
  logic [AW-1:0] statusWord;

  int errors = 0, checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  desc_chain_seq #(.ADDR_W(AW), .BUF_WORDS(BUFW)) i_desc_chain_seq (.*);

  // memory model
  logic [31:0] mem [512];
  logic rspBusy = 1'b0;
  logic stallReg = 1'b0;
  int rspCnt = 0;
  int reqCount = 0, dataWrites = 0, cmplCount = 0, protoErrs = 0;
  logic [31:0] lastCmpl = '0;
  logic prevPend = 1'b0;
  logic [31:0] prevAddr = '0;
  logic prevWrite = 1'b0;

  assign memReqReady = !rspBusy && !stallReg;

  function automatic int widx(input logic [31:0] a);
    return int'(a[10:2]);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    stallReg <= (cyc % 5 == 2);
    memRspValid <= 1'b0;
    if (prevPend && (!memReqValid || memReqAddr != prevAddr || memReqWrite != prevWrite))
      protoErrs <= protoErrs + 1;
    prevPend  <= memReqValid && !memReqReady;
    prevAddr  <= memReqAddr;
    prevWrite <= memReqWrite;
    if (rspBusy) begin
      if (rspCnt == 0) begin
        memRspValid <= 1'b1;
        rspBusy <= 1'b0;
      end else begin
        rspCnt <= rspCnt - 1;
      end
    end else if (memReqValid && memReqReady && rstN) begin
      rspBusy  <= 1'b1;
      rspCnt   <= cyc % 3;
      reqCount <= reqCount + 1;
      if (memReqWrite) begin
        mem[widx(memReqAddr)] <= memReqWdata;
        if (memReqAddr == CMPL_AT) begin
          cmplCount <= cmplCount + 1;
          lastCmpl  <= memReqWdata;
        end else begin
          dataWrites <= dataWrites + 1;
        end
      end else begin
        memRspData <= mem[widx(memReqAddr)];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic putDesc(input logic [31:0] a, input logic [31:0] nxt, input logic [31:0] flags,
                         input logic [31:0] len, input logic [31:0] src, input logic [31:0] dst);
    mem[widx(a)]      = nxt;
    mem[widx(a + 4)]  = flags;
    mem[widx(a + 8)]  = len;
    mem[widx(a + 12)] = src;
    mem[widx(a + 16)] = dst;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) cmdStart = 1'b1;
    else if (which == 1) cmdAppend = 1'b1;
    else cmdReset = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0; cmdAppend = 1'b0; cmdReset = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic waitRead();
    int n = 0;
    while (chanState != 3'd3 && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic checkCopy(input string tag, input logic [31:0] src, input logic [31:0] dst, input int n);
    int bad = 0;
    for (int k = 0; k < n; k++)
      if (mem[widx(dst + 4*k)] !== mem[widx(src + 4*k)]) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic testReset();
    chk("R1 busy after reset", {31'd0, busy}, 0);
    chk("R1 state after reset", {29'd0, chanState}, 0);
    chk("R1 status after reset", statusWord, 32'h6);
    chk("R1 no request", {31'd0, memReqValid}, 0);
  endtask

  task automatic testSingle();
    putDesc(32'h040, 0, 32'h2, 3, 32'h400, 32'h600);
    chainAddr = 32'h040;
    pulse(0);
    waitIdle();
    checkCopy("R3 single copy", 32'h400, 32'h600, 3);
    chk("R3 word past length untouched", mem[widx(32'h60C)], 0);
    chk("R4 completion count", cmplCount, 1);
    chk("R4 completion word", lastCmpl, 32'h041);
    chk("R2 status after start and copy", statusWord, 32'h040);
    pulse(2);
    @(negedge clk);
    chk("R9 reset idle sets status 3", statusWord, 32'h046);
  endtask

  task automatic testChainClamp();
    int c0 = cmplCount;
    putDesc(32'h080, 32'h0A0, 0, 2, 32'h420, 32'h620);
    putDesc(32'h0A0, 0, 0, 12, 32'h440, 32'h640);
    chainAddr = 32'h080;
    pulse(0);
    waitIdle();
    checkCopy("R3 chain first", 32'h420, 32'h620, 2);
    checkCopy("R3 chain second clamped", 32'h440, 32'h640, BUFW);
    chk("R3 clamp stops at buffer size", mem[widx(32'h640 + 4*BUFW)], 0);
    chk("R4 no completion without flag", cmplCount, c0);
    chk("R4 status low bits dropped", statusWord, 32'h080);
  endtask

  task automatic testNull();
    int c0;
    putDesc(32'h100, 32'h140, 32'h1, 2, 32'h480, 32'h680);
    putDesc(32'h140, 0, 32'h2, 1, 32'h490, 32'h690);
    chainAddr = 32'h100;
    pulse(0);
    waitIdle();
    chk("R5 null skips copy", mem[widx(32'h680)], 0);
    checkCopy("R5 null follows next", 32'h490, 32'h690, 1);
    chk("R5 completion from real descriptor", lastCmpl, 32'h141);
    c0 = cmplCount;
    putDesc(32'h180, 0, 32'h3, 1, 32'h480, 32'h6A0);
    chainAddr = 32'h180;
    pulse(0);
    waitIdle();
    chk("R5 lone null no completion", cmplCount, c0);
    chk("R5 lone null status unchanged", statusWord, 32'h140);
    chk("R5 lone null no copy", mem[widx(32'h6A0)], 0);
  endtask

  task automatic testAppendIdle();
    int r0 = reqCount;
    pulse(1);
    waitIdle();
    chk("R7 append zero next single read", reqCount - r0, 1);
    chk("R7 append zero next idle", {31'd0, busy}, 0);
    putDesc(32'h1C0, 0, 32'h2, 2, 32'h4A0, 32'h6B0);
    mem[widx(32'h180)] = 32'h1C0;
    pulse(1);
    waitIdle();
    checkCopy("R7 append follows new next", 32'h4A0, 32'h6B0, 2);
    chk("R7 completion after append", lastCmpl, 32'h1C1);
  endtask

  task automatic testAppendBusy();
    putDesc(32'h200, 0, 0, 8, 32'h4B0, 32'h6C0);
    putDesc(32'h240, 0, 32'h2, 1, 32'h4D0, 32'h6E0);
    chainAddr = 32'h200;
    pulse(0);
    waitRead();
    pulse(1);
    mem[widx(32'h200)] = 32'h240;
    waitIdle();
    checkCopy("R8 first copy", 32'h4B0, 32'h6C0, 8);
    checkCopy("R8 pending append continued", 32'h4D0, 32'h6E0, 1);
    chk("R8 completion of appended", lastCmpl, 32'h241);
  endtask

  task automatic testResetBusy();
    int c0 = cmplCount;
    putDesc(32'h280, 32'h2C0, 32'h2, 4, 32'h4E0, 32'h6F0);
    putDesc(32'h2C0, 0, 0, 1, 32'h4F0, 32'h700);
    chainAddr = 32'h280;
    pulse(0);
    waitRead();
    pulse(2);
    pulse(1);
    waitIdle();
    checkCopy("R9 current descriptor finishes", 32'h4E0, 32'h6F0, 4);
    chk("R6 deferred reset beats next pointer", mem[widx(32'h700)], 0);
    chk("R9 completion still written", cmplCount - c0, 1);
    chk("R9 status after deferred reset", statusWord, 32'h286);
  endtask

  task automatic testStartBusy();
    putDesc(32'h300, 0, 0, 4, 32'h500, 32'h710);
    putDesc(32'h340, 0, 0, 1, 32'h520, 32'h720);
    chainAddr = 32'h300;
    pulse(0);
    waitRead();
    chainAddr = 32'h340;
    pulse(0);
    waitIdle();
    checkCopy("R10 running chain completes", 32'h500, 32'h710, 4);
    chk("R10 second start ignored", mem[widx(32'h720)], 0);
    chk("R10 status from first chain", statusWord, 32'h300);
  endtask

  task automatic testZeroLen();
    int d0 = dataWrites;
    int c0 = cmplCount;
    putDesc(32'h380, 0, 32'h2, 0, 32'h500, 32'h730);
    chainAddr = 32'h380;
    pulse(0);
    waitIdle();
    chk("R12 no data writes", dataWrites - d0, 0);
    chk("R12 completion written", cmplCount - c0, 1);
    chk("R12 completion word", lastCmpl, 32'h381);
    chk("R12 status updated", statusWord, 32'h380);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = (i >= 256 && i < 384) ? (32'hC0DE0000 + i) : 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingle();
    testChainClamp();
    testNull();
    testAppendIdle();
    testAppendBusy();
    testResetBusy();
    testStartBusy();
    testZeroLen();
    chk("R11 request held until accepted", protoErrs, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected below 100000 cycles", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule